// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Controller

This block performs hardware handshaking for a single asynchronous serial channel. On the receive side it drives the active-low request-to-send pin from the fill level of the receive FIFO. The rule it uses depends on the selected receive trigger level. On the transmit side it decides, once per character, whether the serializer may begin the next byte. It bases that decision on the active-low clear-to-send pin.

The channel's modem-control logic supplies two enable bits: the manual request-to-send bit and the automatic-flow bit. The receive FIFO supplies its occupancy count. The receive deserializer marks the first data bit of every incoming character, and the host interface pulses a strobe for each read of the receive buffer. The transmit serializer raises a start request when it has a byte ready. It also pulses a marker in the middle of the last stop bit of the byte it is sending. In return the block grants each start and drives the request-to-send pin. It also tells the interrupt logic to ignore clear-to-send changes while the transmitter gates itself. The serializers, FIFOs and interrupt logic sit outside the block.

Top module: `uart_flow_ctrl`

## Requirements
- R1: Mode decode. With `mcr_afe`=1 and `mcr_rts`=1, both automatic request-to-send and automatic clear-to-send are active. With `mcr_afe`=1 and `mcr_rts`=0, only automatic clear-to-send is active. With `mcr_afe`=0, neither is active: `tx_go` equals `tx_req` whatever `cts_n` is, and the FIFO inputs do not affect `rts_n`.
- R2: `rts_n` is 1 during and right after reset. While automatic request-to-send is off, `rts_n` equals the inverse of `mcr_rts` one clock after the bit is sampled.
- R3: With automatic request-to-send on and `trig_sel` at 00, 01 or 10 (levels 1, 4, 8), `rts_n` goes to 1 one clock after `rx_count` is sampled at or above the level.
- R4: At levels 1, 4 and 8, once `rts_n` has gone high it stays high while `rx_count` is nonzero, even below the level. It returns to 0 one clock after `rx_count` is sampled as 0.
- R5: With `trig_sel`=11 (level 14), `rts_n` goes to 1 one clock after a `rx_first_bit` pulse is sampled while `rx_count` is at least DEPTH-1 (the arrival of the sixteenth character). Fill alone, and first-bit pulses at lower counts, leave it low.
- R6: At level 14, a `host_rd` pulse frees a slot, and `rts_n` returns to 0 one clock later. If both pulses occur in the same cycle, the first-bit pulse wins.
- R7: `cts_n` passes through a two-stage synchronizer. With automatic clear-to-send on and no pending stop-bit sample, `tx_go` follows `tx_req` only while the synchronized pin is low. A change on the pin reaches `tx_go` after two clock edges. `tx_go` is never 1 without `tx_req`.
- R8: A `tx_stop_mid` pulse captures the synchronized clear-to-send state, and the next start follows that capture. If the pin is low at the capture, the next request is granted even when the pin has risen since. If it is high at the capture, the next request is blocked.
- R9: A request blocked by a capture is granted once the synchronized pin reads low again. It stays blocked while the pin stays high.
- R10: `cts_irq_mask` is 1 exactly while `mcr_afe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mcr_rts | input | 1 | Modem-control request-to-send bit |
| mcr_afe | input | 1 | Modem-control automatic-flow enable bit |
| trig_sel | input | 2 | Receive trigger select: 00=1, 01=4, 10=8, 11=14 |
| rx_count | input | CNT_W | Receive FIFO occupancy, 0..DEPTH |
| rx_first_bit | input | 1 | Pulse at the first data bit of an incoming character |
| host_rd | input | 1 | Pulse for each host read of the receive buffer |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_req | input | 1 | Transmitter holds a byte and wants to start it |
| tx_stop_mid | input | 1 | Pulse in the middle of the last stop bit being sent |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_go | output | 1 | Grant to start the requested byte |
| cts_irq_mask | output | 1 | Suppress clear-to-send change interrupts |

## Verification
The hardest case to reach is a stop-bit capture that disagrees with the current pin. The gate must then honour the captured value and ignore the live one, in both directions. The bench sets the pin to a known level and waits out the synchronizer. It pulses the stop marker and then flips the pin. It holds the flipped level long enough to cross both sync stages before raising the request, so the live value and the captured value really differ when the grant is sampled. A separate scenario at level 14 aligns a first-bit pulse with a count of fifteen, and a read strobe with a full FIFO, to exercise the mid-character release and the single-slot re-assert.

// File: rtl/flow_pkg.sv
// Shared definitions for the automatic flow controller.
// Assumes the receive FIFO depth is at least 16 so that level 14 fits.
package flow_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic auto_rts;
        logic auto_cts;
    } flow_mode_t;

    // Fill level in bytes for a trigger select code.
    function automatic int unsigned trig_fill(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/flow_mode_dec.sv
// Decodes the two modem-control bits into the automatic flow modes.
// Purely combinational; the bits are assumed to come from registers.
module flow_mode_dec
    import flow_pkg::*;
(
    input  logic       mcr_rts,
    input  logic       mcr_afe,
    output flow_mode_t mode,
    output logic       irq_mask
);

    // Automatic request-to-send needs both bits; clear-to-send needs only the enable.
    always_comb begin
        mode.auto_rts = mcr_afe & mcr_rts;
        mode.auto_cts = mcr_afe;
        irq_mask      = mcr_afe;
    end

endmodule

// File: rtl/flow_rts_ctrl.sv
// Drives the request-to-send pin from the receive FIFO fill.
// Levels 1/4/8: a threshold release, re-asserted only on empty.
// Level 14: release on the first data bit of the last character that
// fits, re-assert when a host read frees a slot.
// Assumes rx_count is synchronous to clk and never exceeds DEPTH.
module flow_rts_ctrl
    import flow_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts,
    input  logic             mcr_rts,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_first_bit,
    input  logic             host_rd,
    output logic             rts_n
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

    logic             held_q;
    logic             held_d;
    logic [CNT_W-1:0] level;
    logic             late_mode;

    // Decode the selected trigger into a byte count.
    always_comb begin
        level     = CNT_W'(trig_fill(trig_sel));
        late_mode = (trig_sel == TRIG_FOURTEEN);
    end

    // Next state of the "sender must pause" flag.
    always_comb begin
        held_d = held_q;
        if (!auto_rts) begin
            held_d = 1'b0;
        end else if (late_mode) begin
            if (rx_first_bit && (rx_count >= LAST_SLOT)) begin
                held_d = 1'b1;
            end else if (host_rd) begin
                held_d = 1'b0;
            end
        end else begin
            if (rx_count >= level) begin
                held_d = 1'b1;
            end else if (rx_count == '0) begin
                held_d = 1'b0;
            end
        end
    end

    // Register the flag and the pin level; pin idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            rts_n  <= 1'b1;
        end else begin
            held_q <= held_d;
            rts_n  <= auto_rts ? held_d : ~mcr_rts;
        end
    end

endmodule

// File: rtl/flow_cts_sync.sv
// Multi-stage synchronizer for the asynchronous clear-to-send pin.
// Resets to the inactive (high) pin level; output is active-high "ok".
module flow_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic live_ok
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= pin_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    // Active-low pin becomes an active-high permission.
    assign live_ok = ~chain_q[STAGES-1];

endmodule

// File: rtl/flow_tx_gate.sv
// Grants the start of each transmit character.
// At the stop-bit marker the synchronized permission is captured.
// The next start follows the capture until it is consumed, or until
// a blocking capture is overtaken by a returning permission.
// Assumes the serializer raises tx_req only between characters, so a
// grant never interrupts a byte already on the line.
module flow_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_cts,
    input  logic live_ok,
    input  logic tx_req,
    input  logic tx_stop_mid,
    output logic tx_go
);

    logic snap_ok_q;
    logic snap_vld_q;
    logic allow;

    // Choose the captured permission while one is pending.
    always_comb begin
        allow = snap_vld_q ? snap_ok_q : live_ok;
        tx_go = tx_req & (~auto_cts | allow);
    end

    // Capture at the stop-bit marker; retire on use or on recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ok_q  <= 1'b0;
            snap_vld_q <= 1'b0;
        end else if (tx_stop_mid) begin
            snap_ok_q  <= live_ok;
            snap_vld_q <= 1'b1;
        end else if (tx_go || (live_ok && !snap_ok_q)) begin
            snap_vld_q <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_flow_ctrl.sv
// Automatic request-to-send / clear-to-send controller for one channel.
// Connects the mode decoder, the receive-side pin driver, the pin
// synchronizer and the transmit start gate. All inputs except cts_n
// are assumed synchronous to clk.
module uart_flow_ctrl
    import flow_pkg::*;
#(
    parameter  int DEPTH       = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mcr_rts,
    input  logic             mcr_afe,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_first_bit,
    input  logic             host_rd,
    input  logic             cts_n,
    input  logic             tx_req,
    input  logic             tx_stop_mid,
    output logic             rts_n,
    output logic             tx_go,
    output logic             cts_irq_mask
);

    flow_mode_t mode;
    logic       live_ok;

    flow_mode_dec u_mode (
        .mcr_rts  (mcr_rts),
        .mcr_afe  (mcr_afe),
        .mode     (mode),
        .irq_mask (cts_irq_mask)
    );

    flow_rts_ctrl #(.DEPTH(DEPTH)) u_rts (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_rts     (mode.auto_rts),
        .mcr_rts      (mcr_rts),
        .trig_sel     (trig_sel),
        .rx_count     (rx_count),
        .rx_first_bit (rx_first_bit),
        .host_rd      (host_rd),
        .rts_n        (rts_n)
    );

    flow_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (cts_n),
        .live_ok (live_ok)
    );

    flow_tx_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_cts    (mode.auto_cts),
        .live_ok     (live_ok),
        .tx_req      (tx_req),
        .tx_stop_mid (tx_stop_mid),
        .tx_go       (tx_go)
    );

endmodule

// File: rtl/uart_flow_ctrl_chk.sv
// Property checker for uart_flow_ctrl, attached with bind.
// Observes ports only.
module uart_flow_ctrl_chk
    import flow_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mcr_rts,
    input logic             mcr_afe,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_first_bit,
    input logic             tx_req,
    input logic             rts_n,
    input logic             tx_go
);

    logic             auto_on;
    logic             early_mode;
    logic [CNT_W-1:0] lvl;

    always_comb begin
        auto_on    = mcr_afe & mcr_rts;
        early_mode = (trig_sel != TRIG_FOURTEEN);
        lvl        = CNT_W'(trig_fill(trig_sel));
    end

    // R1: with automatic flow off the grant mirrors the request
    p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mcr_afe |-> (tx_go == tx_req));

    // R2: manual pin follows the inverted bit one clock later
    p_manual_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on |=> (rts_n == !$past(mcr_rts)));

    // R3: threshold reached releases the pin
    p_thresh_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && early_mode && (rx_count >= lvl)) |=> rts_n);

    // R4: released pin holds until the FIFO is empty
    p_hold_until_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && $past(auto_on) && early_mode && rts_n && (rx_count != '0)) |=> rts_n);

    // R5: last character arriving releases the pin at level 14
    p_late_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && !early_mode && rx_first_bit && (rx_count >= CNT_W'(DEPTH - 1))) |=> rts_n);

    // R7: no grant without a request
    p_go_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> tx_req);

endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mcr_rts      (mcr_rts),
    .mcr_afe      (mcr_afe),
    .trig_sel     (trig_sel),
    .rx_count     (rx_count),
    .rx_first_bit (rx_first_bit),
    .tx_req       (tx_req),
    .rts_n        (rts_n),
    .tx_go        (tx_go)
);

// File: tb/sim_uart_flow_ctrl.sv
// Directed bench for uart_flow_ctrl: one task per scenario.
module sim_uart_flow_ctrl;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mcr_rts, mcr_afe;
    logic [1:0]       trig_sel;
    logic [CNT_W-1:0] rx_count;
    logic             rx_first_bit, host_rd, cts_n, tx_req, tx_stop_mid;
    logic             rts_n, tx_go, cts_irq_mask;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    uart_flow_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .mcr_rts(mcr_rts), .mcr_afe(mcr_afe),
        .trig_sel(trig_sel), .rx_count(rx_count), .rx_first_bit(rx_first_bit),
        .host_rd(host_rd), .cts_n(cts_n), .tx_req(tx_req),
        .tx_stop_mid(tx_stop_mid), .rts_n(rts_n), .tx_go(tx_go),
        .cts_irq_mask(cts_irq_mask)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mcr_rts = 1'b0; mcr_afe = 1'b0; trig_sel = 2'b00;
        rx_count = '0; rx_first_bit = 1'b0; host_rd = 1'b0; cts_n = 1'b1;
        tx_req = 1'b0; tx_stop_mid = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R2", "rts_n after reset", rts_n, 1'b1);
        check("R7", "tx_go idle after reset", tx_go, 1'b0);
        check("R10", "irq mask with enable off", cts_irq_mask, 1'b0);
    endtask

    task automatic t_manual_pin();
        do_reset();
        mcr_rts = 1'b1; tick();
        check("R2", "manual bit set drives pin low", rts_n, 1'b0);
        rx_count = 5'd16; tick();
        check("R1", "fill ignored with flow off", rts_n, 1'b0);
        mcr_rts = 1'b0; tick();
        check("R2", "manual bit clear drives pin high", rts_n, 1'b1);
        rx_count = '0;
    endtask

    task automatic t_flow_off_pass();
        do_reset();
        cts_n = 1'b1; tick(3);
        tx_req = 1'b1; #1;
        check("R1", "grant ignores pin with flow off", tx_go, 1'b1);
        check("R10", "mask low with flow off", cts_irq_mask, 1'b0);
        tick(); tx_req = 1'b0;
    endtask

    task automatic t_cts_only();
        do_reset();
        mcr_afe = 1'b1; mcr_rts = 1'b0; trig_sel = 2'b00; rx_count = 5'd16; tick();
        check("R1", "clear-to-send only: pin follows manual bit", rts_n, 1'b1);
        check("R10", "mask high with enable", cts_irq_mask, 1'b1);
        tx_req = 1'b1; #1;
        check("R1", "clear-to-send only gates inactive pin", tx_go, 1'b0);
        rx_count = '0; tx_req = 1'b0;
    endtask

    task automatic t_sync_delay();
        do_reset();
        mcr_afe = 1'b1; tick(3);
        tx_req = 1'b1; cts_n = 1'b0; #1;
        check("R7", "blocked before sync", tx_go, 1'b0);
        tick(); #1;
        check("R7", "still blocked after one edge", tx_go, 1'b0);
        tick(); #1;
        check("R7", "granted after two edges", tx_go, 1'b1);
        tx_req = 1'b0; tick();
    endtask

    task automatic t_threshold(input logic [1:0] sel, input int lvl);
        do_reset();
        mcr_afe = 1'b1; mcr_rts = 1'b1; trig_sel = sel; rx_count = '0; tick();
        check("R3", $sformatf("level %0d pin low when empty", lvl), rts_n, 1'b0);
        if (lvl > 1) begin
            rx_count = CNT_W'(lvl - 1); tick();
            check("R3", $sformatf("level %0d below threshold", lvl), rts_n, 1'b0);
        end
        rx_count = CNT_W'(lvl); tick();
        check("R3", $sformatf("level %0d released at threshold", lvl), rts_n, 1'b1);
        rx_count = CNT_W'(lvl + 1); tick();
        rx_count = 5'd1; tick();
        check("R4", $sformatf("level %0d held with one byte left", lvl), rts_n, 1'b1);
        rx_count = '0; tick();
        check("R4", $sformatf("level %0d re-asserted on empty", lvl), rts_n, 1'b0);
    endtask

    task automatic t_fourteen();
        do_reset();
        mcr_afe = 1'b1; mcr_rts = 1'b1; trig_sel = 2'b11; rx_count = 5'd14; tick();
        check("R5", "level 14 low at fill 14", rts_n, 1'b0);
        rx_count = 5'd10; rx_first_bit = 1'b1; tick();
        rx_first_bit = 1'b0;
        check("R5", "first bit at low fill ignored", rts_n, 1'b0);
        rx_count = 5'd15; tick();
        check("R5", "fill 15 alone keeps pin low", rts_n, 1'b0);
        rx_first_bit = 1'b1; host_rd = 1'b1; tick();
        rx_first_bit = 1'b0; host_rd = 1'b0;
        check("R6", "first bit wins over read in same cycle", rts_n, 1'b1);
        rx_count = 5'd16; tick(2);
        check("R5", "held while full", rts_n, 1'b1);
        host_rd = 1'b1; tick();
        host_rd = 1'b0; rx_count = 5'd15;
        check("R6", "read frees a slot and re-asserts", rts_n, 1'b0);
        rx_count = '0; tick();
    endtask

    task automatic t_late_release();
        do_reset();
        mcr_afe = 1'b1; cts_n = 1'b0; tick(3);
        tx_stop_mid = 1'b1; tick(); tx_stop_mid = 1'b0;
        cts_n = 1'b1; tick(4);
        tx_req = 1'b1; #1;
        check("R8", "captured permission starts next byte", tx_go, 1'b1);
        tick(); #1;
        check("R7", "after capture consumed pin blocks", tx_go, 1'b0);
        tx_req = 1'b0; tick();
    endtask

    task automatic t_early_block();
        do_reset();
        mcr_afe = 1'b1; cts_n = 1'b1; tick(3);
        tx_stop_mid = 1'b1; tick(); tx_stop_mid = 1'b0;
        tx_req = 1'b1; #1;
        check("R8", "captured block stops next byte", tx_go, 1'b0);
        tick(4); #1;
        check("R9", "remains blocked while pin high", tx_go, 1'b0);
        cts_n = 1'b0; tick(5); #1;
        check("R9", "granted after pin returns", tx_go, 1'b1);
        tx_req = 1'b0; tick();
    endtask

    initial begin
        t_reset_state();
        t_manual_pin();
        t_flow_off_pass();
        t_cts_only();
        t_sync_delay();
        t_threshold(2'b00, 1);
        t_threshold(2'b01, 4);
        t_threshold(2'b10, 8);
        t_fourteen();
        t_late_release();
        t_early_block();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule